// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Port

A full-duplex asynchronous serial port with three frame formats, reached through a small register window. Software writes bytes to a transmit buffer, reads received bytes from a two-entry receive buffer at the same address, sets the frame format through a write-only control register, and polls or takes interrupts from a status register whose event flags clear when it is read.

The ninth frame bit can serve as software data, as even parity, or as an address marker. In the address-filter format a received frame whose ninth bit is 0 is dropped in hardware and never reaches software. A node therefore sleeps through traffic meant for others until an address frame arrives. It then switches to the plain nine-bit format to collect the data that follows. The bit clock comes from a 16-bit divider register loaded one byte at a time. Its top bit picks between the system clock and an external tick.

Top module: `mp_uart`

## Requirements
- R1: After reset the line output is 1, both interrupt outputs are 0 and the status register reads 0x00.
- R2: The divider register at address 2 takes two byte writes, low byte first and then high byte. Bit 15 = 1 makes the divider advance on every clock and gives a bit time of 64*(B+1) clocks, where B is bits 14:0. Bit 15 = 0 makes it advance only on clocks where `ext_tick` is high, giving 64*(B+1) ticks per bit.
- R3: Control bits [1:0] select the format: 01 (00 behaves alike) gives a 10-bit frame: a 0 start bit, 8 data bits LSB first, and a 1 stop bit. With the parity enable (control bit 2) set, data position 7 carries even parity of data bits 6:0.
- R4: Formats 10 and 11 send 11-bit frames: a start bit, 8 data bits, a ninth bit and a stop bit. The ninth bit is control bit 3 (TB8) in format 10, and in format 11 with parity off. In format 11 with parity on, it is the even parity of the 8 data bits.
- R5: TB8 clears when a byte moves from the transmit buffer into the shifter. TI (status bit 1) sets at the end of the stop bit, and `tx_int` follows TI.
- R6: The receiver samples the line 16 times per bit and takes each bit as the majority of samples 7, 8 and 9. A completed frame sets RI (status bit 0), and `rx_int` follows RI. In format 11 with parity off, status bit 2 reports the ninth bit of the oldest unread byte.
- R7: In format 10 a received frame whose ninth bit is 0 is discarded without setting RI. One whose ninth bit is 1 is stored with status bit 2 = 1.
- R8: With parity on, status bit 2 reports a parity error for the oldest unread byte. In format 11 the check is even parity over data and ninth bit; in format 01 it is even parity over the 8 received data bits.
- R9: A received stop bit of 0 sets the framing flag (status bit 3). The byte is still stored.
- R10: Two received bytes wait unread. A third byte completing while both are waiting is discarded and sets the overrun flag (status bit 4).
- R11: Reading the status register (address 1) clears RI, TI, framing and overrun. A flag that sets in the same cycle as the read stays set.
- R12: Address 0 is shared: a write loads the transmit buffer, and a read returns the oldest unread received byte and removes it.
- R13: A low pulse on the line shorter than half a bit starts no frame and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 data, 1 control/status, 2 divider |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe; drives read side effects |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| ext_tick | input | 1 | External divider advance when bit 15 of divider is 0 |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_int | output | 1 | Receive interrupt (level of RI) |
| tx_int | output | 1 | Transmit interrupt (level of TI) |

## Verification
The collision that matters is a status read landing in the very clock where the stop bit of an outgoing frame ends and TI sets. The bench watches its own model and, when it predicts that the next edge finishes the frame, issues the status read in exactly that cycle. The read must return TI = 0, and after the edge `tx_int` must be 1. The model, compared on every clock, treats set as winning over clear, so a lost flag shows up as a line and interrupt mismatch.

// File: rtl/mp_uart.sv
`timescale 1ns/1ps
module mp_uart (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr,
  input  logic       rd,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_tick,
  input  logic       rxd,
  output logic       txd,
  output logic       rx_int,
  output logic       tx_int
);
  localparam logic [1:0] A_DATA = 2'd0, A_CSR = 2'd1, A_DIV = 2'd2;

  logic [15:0] divr;
  logic        div_hi;
  logic [1:0]  pre;
  logic [14:0] dcnt;
  logic [1:0]  mode;
  logic        pen, tb8;

  wire wr_dat = wr && addr == A_DATA;
  wire wr_ctl = wr && addr == A_CSR;
  wire wr_div = wr && addr == A_DIV;
  wire rd_dat = rd && addr == A_DATA;
  wire rd_st  = rd && addr == A_CSR;
  wire long9  = mode[1];

  wire adv  = divr[15] | ext_tick;
  wire tick = adv && pre == 2'd3 && dcnt >= divr[14:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      divr <= '0; div_hi <= 1'b0; pre <= '0; dcnt <= '0;
    end else begin
      if (wr_div) begin
        if (div_hi) divr[15:8] <= wdata; else divr[7:0] <= wdata;
        div_hi <= ~div_hi;
      end
      if (adv) begin
        pre <= pre + 2'd1;
        if (pre == 2'd3) dcnt <= tick ? '0 : dcnt + 15'd1;
      end
    end

  // transmitter
  logic [7:0]  tx_buf;
  logic        tx_full, tx_busy, ti;
  logic [10:0] tx_sh;
  logic [3:0]  tx_left, tx_sub;

  wire [7:0] tx_byte  = (!long9 && pen) ? {^tx_buf[6:0], tx_buf[6:0]} : tx_buf;
  wire       tx_nin   = (mode == 2'b11 && pen) ? ^tx_buf : tb8;
  wire       tx_start = !tx_busy && tx_full;
  wire       tx_done  = tx_busy && tick && tx_sub == 4'd15 && tx_left == 4'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_buf <= '0; tx_full <= 1'b0; tx_busy <= 1'b0; tx_sh <= '1;
      tx_left <= '0; tx_sub <= '0; ti <= 1'b0; tb8 <= 1'b0; mode <= 2'b01; pen <= 1'b0;
    end else begin
      if (tx_start) begin
        tx_sh   <= long9 ? {1'b1, tx_nin, tx_byte, 1'b0} : {2'b11, tx_byte, 1'b0};
        tx_left <= long9 ? 4'd11 : 4'd10;
        tx_sub  <= '0;
        tx_busy <= 1'b1;
      end else if (tx_busy && tick) begin
        tx_sub <= tx_sub + 4'd1;
        if (tx_sub == 4'd15) begin
          tx_sh   <= {1'b1, tx_sh[10:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end
      end
      if (wr_dat) begin tx_buf <= wdata; tx_full <= 1'b1; end
      else if (tx_start) tx_full <= 1'b0;
      if (wr_ctl) begin mode <= wdata[1:0]; pen <= wdata[2]; tb8 <= wdata[3]; end
      else if (tx_start) tb8 <= 1'b0;
      if (tx_done) ti <= 1'b1;
      else if (rd_st) ti <= 1'b0;
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  logic [1:0] rsync, rv;
  logic       rx_busy, ri, fe, oe;
  logic [3:0] rx_sub, rx_cnt;
  logic [8:0] rx_sh, rb0, rb1;
  logic [1:0] rcnt;

  wire       rx_s    = rsync[1];
  wire       vote    = (rv[1] & rv[0]) | (rv[1] & rx_s) | (rv[0] & rx_s);
  wire [3:0] rx_last = long9 ? 4'd10 : 4'd9;
  wire       rx_mid  = rx_busy && tick && rx_sub == 4'd9;
  wire       rx_end  = rx_mid && rx_cnt == rx_last;
  wire [7:0] rx_data = long9 ? rx_sh[7:0] : rx_sh[8:1];
  wire       rx_nin  = long9 & rx_sh[8];
  wire       rx_flag = long9 ? ((mode[0] && pen) ? ^{rx_nin, rx_data} : rx_nin)
                             : (pen & ^rx_data);
  wire       push    = rx_end && !(mode == 2'b10 && !rx_nin);
  wire       pop     = rd_dat && rcnt != 2'd0;
  wire       ovf     = push && rcnt == 2'd2 && !pop;
  wire       ins     = push && !ovf;
  wire [8:0] rx_ent  = {rx_flag, rx_data};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsync <= 2'b11; rv <= '0; rx_busy <= 1'b0; rx_sub <= '0; rx_cnt <= '0; rx_sh <= '0;
    end else begin
      rsync <= {rsync[0], rxd};
      if (!rx_busy) begin
        if (tick && !rx_s) begin rx_busy <= 1'b1; rx_sub <= 4'd1; rx_cnt <= '0; end
      end else if (tick) begin
        rx_sub <= rx_sub + 4'd1;
        if (rx_sub == 4'd7 || rx_sub == 4'd8) rv <= {rv[0], rx_s};
        if (rx_sub == 4'd9) begin
          if ((rx_cnt == 4'd0 && vote) || rx_cnt == rx_last) rx_busy <= 1'b0;
          else begin
            if (rx_cnt != 4'd0) rx_sh <= {vote, rx_sh[8:1]};
            rx_cnt <= rx_cnt + 4'd1;
          end
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rb0 <= '0; rb1 <= '0; rcnt <= '0; ri <= 1'b0; fe <= 1'b0; oe <= 1'b0;
    end else begin
      case ({ins, pop})
        2'b10: begin
          if (rcnt == 2'd0) rb0 <= rx_ent; else rb1 <= rx_ent;
          rcnt <= rcnt + 2'd1;
        end
        2'b01: begin rb0 <= rb1; rcnt <= rcnt - 2'd1; end
        2'b11: begin
          if (rcnt == 2'd1) rb0 <= rx_ent;
          else begin rb0 <= rb1; rb1 <= rx_ent; end
        end
        default: ;
      endcase
      if (ins) ri <= 1'b1; else if (rd_st) ri <= 1'b0;
      if (rx_end && !vote) fe <= 1'b1; else if (rd_st) fe <= 1'b0;
      if (ovf) oe <= 1'b1; else if (rd_st) oe <= 1'b0;
    end

  always_comb
    case (addr)
      A_DATA:  rdata = rb0[7:0];
      A_CSR:   rdata = {3'b000, oe, fe, rcnt != 2'd0 && rb0[8], ti, ri};
      default: rdata = 8'h00;
    endcase

  assign rx_int = ri;
  assign tx_int = ti;
endmodule

// File: rtl/mp_uart_chk.sv
`timescale 1ns/1ps
module mp_uart_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_busy,
  input logic       ti,
  input logic       tb8,
  input logic       wr,
  input logic       rd,
  input logic [1:0] addr,
  input logic [1:0] rcnt,
  input logic       oe,
  input logic       ri
);
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd) else $error("start bit not low"); // R3
  AST_TI_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ti) else $error("TI missing at frame end"); // R5
  AST_TB8_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) && !$past(wr && addr == 2'd1) |-> !tb8) else $error("TB8 kept"); // R5
  AST_RX_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    rcnt <= 2'd2) else $error("receive buffer depth"); // R10
  AST_OVERRUN_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe) |-> $past(rcnt) == 2'd2) else $error("overrun without full buffer"); // R10
  AST_RI_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ri) |-> $past(rd && addr == 2'd1)) else $error("RI cleared without read"); // R11
endmodule

bind mp_uart mp_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .ti(ti), .tb8(tb8),
  .wr(wr), .rd(rd), .addr(addr), .rcnt(rcnt), .oe(oe), .ri(ri)
);

// File: tb/mp_uart_test.sv
`timescale 1ns/1ps
module mp_uart_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, ext_tick = 1'b0, rxd = 1'b1;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic txd, rx_int, tx_int;

  mp_uart uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
               .rdata(rdata), .ext_tick(ext_tick), .rxd(rxd), .txd(txd),
               .rx_int(rx_int), .tx_int(tx_int));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  string cur = "R3";

  task automatic check(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // behavioural transmit-side reference
  bit m_int, m_hi, m_full, m_busy, m_ti, m_tb8, m_pen, m_txd = 1;
  int m_b, m_ph, m_sub;
  logic [1:0] m_mode;
  logic [7:0] m_buf;
  bit mq[$];

  function automatic bit tick_next(bit et);
    return (m_int || et) && (m_ph % 4 == 3) && (m_ph / 4 >= m_b);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_int = 0; m_hi = 0; m_full = 0; m_busy = 0; m_ti = 0; m_tb8 = 0; m_pen = 0;
      m_b = 0; m_ph = 0; m_sub = 0; m_mode = 2'b01; m_buf = 0; mq.delete(); m_txd = 1;
    end else begin
      bit tk, set_ti;
      tk = tick_next(ext_tick);
      set_ti = 0;
      if (m_int || ext_tick) m_ph = tk ? 0 : m_ph + 1;
      if (m_busy) begin
        if (tk) begin
          if (m_sub == 15) begin
            m_sub = 0;
            void'(mq.pop_front());
            if (mq.size() == 0) begin m_busy = 0; set_ti = 1; end
          end else m_sub++;
        end
      end else if (m_full) begin
        logic [7:0] d;
        bit n;
        d = m_buf;
        if (!m_mode[1] && m_pen) d[7] = ^m_buf[6:0];
        n = (m_mode == 2'b11 && m_pen) ? ^m_buf : m_tb8;
        mq.delete();
        mq.push_back(0);
        for (int i = 0; i < 8; i++) mq.push_back(d[i]);
        if (m_mode[1]) mq.push_back(n);
        mq.push_back(1);
        m_busy = 1; m_sub = 0; m_full = 0; m_tb8 = 0;
      end
      if (rd && addr == 2'd1) m_ti = 0;
      if (set_ti) m_ti = 1;
      if (wr && addr == 2'd0) begin m_buf = wdata; m_full = 1; end
      if (wr && addr == 2'd1) begin m_mode = wdata[1:0]; m_pen = wdata[2]; m_tb8 = wdata[3]; end
      if (wr && addr == 2'd2) begin
        if (m_hi) begin m_int = wdata[7]; m_b = (m_b & 32'hFF) | (int'(wdata[6:0]) << 8); end
        else m_b = (m_b & 32'h7F00) | int'(wdata);
        m_hi = !m_hi;
      end
      m_txd = m_busy ? mq[0] : 1'b1;
    end
  end

  always @(negedge clk)
    if (rst_n && !done) begin
      check(cur, "txd", int'(txd), int'(m_txd));
      check("R5", "tx_int", int'(tx_int), int'(m_ti));
    end

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic tx_wait();
    while (m_busy || m_full) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit has9, input bit b9, input bit stopb);
    int bt;
    bt = 64;
    @(negedge clk);
    rxd = 0; repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bt) @(negedge clk); end
    if (has9) begin rxd = b9; repeat (bt) @(negedge clk); end
    rxd = stopb; repeat (bt) @(negedge clk);
    rxd = 1; repeat (bt) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "txd", int'(txd), 1);
    check("R1", "rx_int", int'(rx_int), 0);
    check("R1", "tx_int", int'(tx_int), 0);
    rd_reg(2'd1, v); check("R1", "status", int'(v), 0);

    // R2: internal clock, B=0
    wr_reg(2'd2, 8'h00); wr_reg(2'd2, 8'h80);
    // R3 plain and parity 10-bit frames
    cur = "R3";
    wr_reg(2'd1, 8'h01); wr_reg(2'd0, 8'h5A); tx_wait();
    wr_reg(2'd1, 8'h05); wr_reg(2'd0, 8'hFF); tx_wait();
    // R4 11-bit frames; R5 TB8 self-clears between two queued bytes
    cur = "R4";
    wr_reg(2'd1, 8'h0B); wr_reg(2'd0, 8'h33); wr_reg(2'd0, 8'h34); tx_wait();
    wr_reg(2'd1, 8'h07); wr_reg(2'd0, 8'h81); tx_wait();
    wr_reg(2'd1, 8'h0A); wr_reg(2'd0, 8'hC4); tx_wait();
    // R11: status read in the cycle TI sets
    cur = "R11";
    wr_reg(2'd1, 8'h01);
    rd_reg(2'd1, v);
    wr_reg(2'd0, 8'h96);
    while (!(m_busy && mq.size() == 1 && m_sub == 15 && tick_next(1'b0))) @(negedge clk);
    addr = 2'd1; rd = 1; #1 v = rdata;
    check("R11", "TI before set", int'(v[1]), 0);
    @(negedge clk); rd = 0;
    check("R11", "tx_int kept after collision", int'(tx_int), 1);
    rd_reg(2'd1, v);
    check("R11", "TI cleared by later read", int'(tx_int), 0);

    // receive tests, format 01
    cur = "R6";
    send_rx(8'hA5, 0, 0, 1);
    check("R6", "rx_int", int'(rx_int), 1);
    rd_reg(2'd1, v); check("R6", "status", int'(v), 8'h01);
    check("R11", "rx_int after status read", int'(rx_int), 0);
    rd_reg(2'd0, v); check("R12", "data", int'(v), 8'hA5);
    // R9 framing
    send_rx(8'h5C, 0, 0, 0);
    rd_reg(2'd1, v); check("R9", "status", int'(v), 8'h09);
    rd_reg(2'd0, v); check("R9", "data", int'(v), 8'h5C);
    rd_reg(2'd1, v); check("R11", "FE cleared", int'(v), 8'h00);
    // R13 false start
    @(negedge clk); rxd = 0; repeat (8) @(negedge clk); rxd = 1;
    repeat (300) @(negedge clk);
    check("R13", "rx_int", int'(rx_int), 0);
    rd_reg(2'd1, v); check("R13", "status", int'(v), 8'h00);
    // R8 format 01 with parity
    wr_reg(2'd1, 8'h05);
    send_rx(8'h03, 0, 0, 1);
    rd_reg(2'd1, v); check("R8", "good parity status", int'(v), 8'h01);
    rd_reg(2'd0, v); check("R8", "data", int'(v), 8'h03);
    send_rx(8'h07, 0, 0, 1);
    rd_reg(2'd1, v); check("R8", "bad parity status", int'(v), 8'h05);
    rd_reg(2'd0, v); check("R8", "data", int'(v), 8'h07);
    // R7 address filter
    wr_reg(2'd1, 8'h02);
    send_rx(8'h42, 1, 0, 1);
    check("R7", "rx_int dropped frame", int'(rx_int), 0);
    rd_reg(2'd1, v); check("R7", "status dropped frame", int'(v), 8'h00);
    send_rx(8'h43, 1, 1, 1);
    rd_reg(2'd1, v); check("R7", "status address frame", int'(v), 8'h05);
    rd_reg(2'd0, v); check("R7", "data", int'(v), 8'h43);
    // R8 format 11 with parity
    wr_reg(2'd1, 8'h07);
    send_rx(8'h81, 1, 0, 1);
    rd_reg(2'd1, v); check("R8", "format 11 good parity", int'(v), 8'h01);
    rd_reg(2'd0, v);
    send_rx(8'h81, 1, 1, 1);
    rd_reg(2'd1, v); check("R8", "format 11 bad parity", int'(v), 8'h05);
    rd_reg(2'd0, v);
    // R10 overrun, format 11 parity off (ninth bit reported, R6)
    wr_reg(2'd1, 8'h03);
    send_rx(8'h11, 1, 0, 1);
    send_rx(8'h22, 1, 1, 1);
    send_rx(8'h33, 1, 1, 1);
    rd_reg(2'd1, v); check("R10", "overrun status", int'(v), 8'h11);
    rd_reg(2'd0, v); check("R10", "first byte", int'(v), 8'h11);
    rd_reg(2'd1, v); check("R6", "ninth bit of second byte", int'(v), 8'h04);
    rd_reg(2'd0, v); check("R10", "second byte", int'(v), 8'h22);
    rd_reg(2'd1, v); check("R10", "empty status", int'(v), 8'h00);

    // R2: B=1 internal, then external tick
    cur = "R2";
    wr_reg(2'd2, 8'h01); wr_reg(2'd2, 8'h80);
    wr_reg(2'd1, 8'h01); wr_reg(2'd0, 8'h6E); tx_wait();
    wr_reg(2'd2, 8'h00); wr_reg(2'd2, 8'h00);
    wr_reg(2'd0, 8'hB1);
    repeat (40) @(negedge clk);
    check("R2", "held without ext_tick", int'(txd), 0);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk); ext_tick = (k % 2 == 0);
    end
    ext_tick = 0;
    check("R2", "frame done on ext ticks", int'(m_busy), 0);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule